// File: doc/BRIEF.md
# SDRAM Refresh and Self-Refresh Sequencer

This block lives inside an SDRAM memory controller and owns the refresh duty of the device. A down-counting interval timer marks when a distributed AUTO REFRESH is due. The block then asks the main command arbiter for the command bus and, once granted, closes every bank with a precharge-all. It waits out the precharge recovery time, issues the refresh, and then keeps the bus quiet for the refresh cycle time. All delays are counted in clock cycles and set by parameters.

The same path also carries the system into the device's self-refreshing low-power state. When a low-power request is seen while the sequencer is idle, the refresh command is issued with the clock-enable pin dropped in the same cycle. The pin is held low for at least the minimum row-active time and for as long as the request stays high. When the request falls, the pin is raised, NOPs are driven for the exit recovery time, and one refresh follows at once. Distributed refresh then carries on from that point.

The arbiter sees a request line that stays high until it grants. It also sees a busy line that is high whenever the sequencer is anywhere but idle, and it must not drive commands while busy is high.

Top module: `sdram_refresh_seq`

## Requirements
- R1: During and just after reset, cke is 1, the command bus carries NOP (cs_n=0, ras_n=1, cas_n=1, we_n=1), and arb_req and busy are 0.
- R2: When a refresh falls due or a low-power request is accepted, arb_req rises and stays at 1 until arb_gnt is sampled 1. No non-NOP command appears before that grant.
- R3: Every refresh started from idle is preceded by a PRECHARGE (cs_n=0, ras_n=0, cas_n=1, we_n=0) with a10=1. The refresh follows that precharge by exactly T_RP cycles.
- R4: AUTO REFRESH is cs_n=0, ras_n=0, cas_n=0, we_n=1 with cke=1. With arb_gnt held at 1, consecutive distributed refreshes are exactly REF_INTERVAL+2+T_RP cycles apart.
- R5: After any refresh command, the next PRECHARGE comes no earlier than T_RC cycles later, and only NOP is driven in between.
- R6: When a refresh is due and a low-power request is present in the same idle cycle, the AUTO REFRESH is performed first and self refresh follows it.
- R7: Self refresh is entered with the refresh encoding while cke falls to 0 in the same cycle. Entry comes exactly T_RP cycles after a precharge-all.
- R8: After entry, cke stays 0 and NOP is driven for at least T_RAS+1 cycles, and for as long as lp_req stays 1. No refresh is issued while cke is 0.
- R9: When lp_req is 0 with the minimum hold over, cke returns to 1 on the next cycle. NOP is driven for max(T_XSR,2) cycles, and an AUTO REFRESH without a precharge follows exactly that many cycles after cke rose.
- R10: After the refresh that closes a self-refresh exit, distributed refreshes resume with the R4 spacing.
- R11: lp_req is only acted on in the idle state. A request that rises and falls while the sequencer is busy has no effect: cke stays 1 and refreshes continue.
- R12: busy is 1 in every state except idle, including the whole of self refresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lp_req | input | 1 | Level request: 1 to enter and remain in self refresh, 0 to leave |
| arb_gnt | input | 1 | Command bus grant from the main arbiter |
| arb_req | output | 1 | Request for the command bus |
| busy | output | 1 | Sequencer owns or is waiting on the bus; arbiter must stay off |
| cs_n | output | 1 | SDRAM chip select, active low |
| ras_n | output | 1 | SDRAM row strobe, active low |
| cas_n | output | 1 | SDRAM column strobe, active low |
| we_n | output | 1 | SDRAM write enable, active low |
| cke | output | 1 | SDRAM clock enable |
| a10 | output | 1 | Address bit 10; 1 selects all banks on precharge |

## Verification
The embedded properties assume that the arbiter never drives the SDRAM bus while busy is high. They also assume that timing parameters are at least 2 cycles and that T_RC is shorter than the refresh interval. The bench keeps to this by using one small configuration whose values meet those bounds, and by holding arb_gnt only as a plain level. lp_req is changed only at falling edges, at cycles the bench computes from the last observed refresh. This places the priority collision and the busy-time request pulse on exact cycles and never in an unintended state.

// File: rtl/refseq_pkg.sv
// Package: shared types for the refresh sequencer.
// Assumes: command bus encodings follow the common SDRAM truth table.
package refseq_pkg;

    // Kind of command the sequencer drives this cycle.
    typedef enum logic [1:0] {
        OP_NOP = 2'd0,
        OP_PRE = 2'd1,
        OP_REF = 2'd2
    } op_e;

    // Control states of the sequencer.
    typedef enum logic [3:0] {
        ST_IDLE    = 4'd0,
        ST_REQ     = 4'd1,
        ST_PRE     = 4'd2,
        ST_WAIT_RP = 4'd3,
        ST_REF     = 4'd4,
        ST_WAIT_RC = 4'd5,
        ST_SR_HOLD = 4'd6,
        ST_SR_STAY = 4'd7,
        ST_SR_EXIT = 4'd8
    } state_e;

    // Active-low command strobes.
    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } cmd_bus_t;

endpackage

// File: rtl/refseq_interval.sv
// Module: refseq_interval
// Counts down the distributed-refresh interval and raises 'due' when it
// reaches zero. 'due' stays high until 'restart' reloads the count.
// 'hold' keeps the count reloaded (used while the device refreshes itself).
// Assumes: INTERVAL >= 2.
module refseq_interval #(
    parameter int INTERVAL = 780
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic hold,
    output logic due
);
    localparam int IW = $clog2(INTERVAL);
    localparam logic [IW-1:0] RELOAD = IW'(INTERVAL - 1);

    logic [IW-1:0] cnt;

    // Purpose: reload on restart/hold, otherwise count down to zero and stop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= RELOAD;
        end else if (restart || hold) begin
            cnt <= RELOAD;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign due = (cnt == '0);

    // R4: once due, the flag holds until the sequencer restarts the interval.
    a_r4_due_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (due && !restart && !hold) |=> due);

endmodule

// File: rtl/refseq_delay.sv
// Module: refseq_delay
// Shared wait counter for tRP, tRC, tRAS and the self-refresh exit time.
// A load sets the remaining count; 'done' is high when it sits at zero.
// Assumes: only one wait is in progress at a time (enforced by the FSM).
module refseq_delay #(
    parameter int MAXV = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       load,
    input  logic [$clog2(MAXV+1)-1:0]  load_val,
    output logic                       done
);
    localparam int DW = $clog2(MAXV + 1);

    logic [DW-1:0] cnt;

    // Purpose: load has priority; otherwise step down toward zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign done = (cnt == '0);

    // R5: a load never asks for more than the counter was sized for.
    a_r5_load_range: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (load_val <= DW'(MAXV)));

endmodule

// File: rtl/refseq_cmd_enc.sv
// Module: refseq_cmd_enc
// Maps an abstract operation onto the active-low command strobes.
// Assumes: only NOP, precharge and refresh are ever requested.
module refseq_cmd_enc
    import refseq_pkg::*;
(
    input  op_e      op,
    output cmd_bus_t bus
);
    // Purpose: truth-table decode of the operation.
    always_comb begin
        unique case (op)
            OP_PRE:  bus = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
            OP_REF:  bus = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};
            default: bus = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
        endcase
    end
endmodule

// File: rtl/sdram_refresh_seq.sv
// Module: sdram_refresh_seq (top)
// Sequences distributed AUTO REFRESH and self-refresh entry/exit for one
// SDRAM rank. Every refresh from idle is: request bus -> precharge all ->
// wait T_RP -> refresh -> wait T_RC. Self refresh uses the same path with
// cke dropped on the refresh cycle, holds cke low for T_RAS and while
// lp_req is high, then drives NOP for max(T_XSR,2) cycles and refreshes.
// Assumes: timing parameters >= 2 cycles, T_RC < REF_INTERVAL, and the
// arbiter issues nothing while busy is high.
module sdram_refresh_seq
    import refseq_pkg::*;
#(
    parameter int REF_INTERVAL = 780,
    parameter int T_RP         = 3,
    parameter int T_RC         = 9,
    parameter int T_RAS        = 6,
    parameter int T_XSR        = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lp_req,
    input  logic arb_gnt,
    output logic arb_req,
    output logic busy,
    output logic cs_n,
    output logic ras_n,
    output logic cas_n,
    output logic we_n,
    output logic cke,
    output logic a10
);
    // Derived wait lengths (loads are length-2 for the fixed-state waits).
    localparam int XSR_CYC = (T_XSR > 2) ? T_XSR : 2;
    localparam int RP_LD   = (T_RP  > 2) ? T_RP  - 2 : 0;
    localparam int RC_LD   = (T_RC  > 2) ? T_RC  - 2 : 0;
    localparam int RAS_LD  = (T_RAS > 2) ? T_RAS - 2 : 0;
    localparam int XSR_LD  = XSR_CYC - 1;
    localparam int M1      = (RP_LD > RC_LD) ? RP_LD : RC_LD;
    localparam int M2      = (RAS_LD > XSR_LD) ? RAS_LD : XSR_LD;
    localparam int DLY_MAX = (M1 > M2) ? M1 : M2;
    localparam int DW      = $clog2(DLY_MAX + 1);

    state_e         state, state_nxt;
    logic           self_kind, self_kind_nxt;
    logic           due, dly_done, dly_load;
    logic [DW-1:0]  dly_val;
    op_e            op;
    cmd_bus_t       bus;

    refseq_interval #(.INTERVAL(REF_INTERVAL)) u_interval (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (state == ST_REF),
        .hold    (state == ST_SR_HOLD || state == ST_SR_STAY || state == ST_SR_EXIT),
        .due     (due)
    );

    refseq_delay #(.MAXV(DLY_MAX)) u_delay (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (dly_load),
        .load_val (dly_val),
        .done     (dly_done)
    );

    refseq_cmd_enc u_enc (
        .op  (op),
        .bus (bus)
    );

    // Purpose: next-state, wait loading and refresh-kind selection.
    always_comb begin
        state_nxt     = state;
        self_kind_nxt = self_kind;
        dly_load      = 1'b0;
        dly_val       = '0;
        unique case (state)
            ST_IDLE: begin
                if (due) begin
                    self_kind_nxt = 1'b0;
                    state_nxt     = ST_REQ;
                end else if (lp_req) begin
                    self_kind_nxt = 1'b1;
                    state_nxt     = ST_REQ;
                end
            end
            ST_REQ: if (arb_gnt) state_nxt = ST_PRE;
            ST_PRE: begin
                dly_load  = 1'b1;
                dly_val   = DW'(RP_LD);
                state_nxt = ST_WAIT_RP;
            end
            ST_WAIT_RP: if (dly_done) state_nxt = ST_REF;
            ST_REF: begin
                dly_load  = 1'b1;
                dly_val   = self_kind ? DW'(RAS_LD) : DW'(RC_LD);
                state_nxt = self_kind ? ST_SR_HOLD : ST_WAIT_RC;
            end
            ST_WAIT_RC: if (dly_done) state_nxt = ST_IDLE;
            ST_SR_HOLD: if (dly_done) state_nxt = ST_SR_STAY;
            ST_SR_STAY: begin
                if (!lp_req) begin
                    dly_load  = 1'b1;
                    dly_val   = DW'(XSR_LD);
                    state_nxt = ST_SR_EXIT;
                end
            end
            ST_SR_EXIT: begin
                if (dly_done) begin
                    self_kind_nxt = 1'b0;
                    state_nxt     = ST_REF;
                end
            end
            default: state_nxt = ST_IDLE;
        endcase
    end

    // Purpose: state and refresh-kind registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            self_kind <= 1'b0;
        end else begin
            state     <= state_nxt;
            self_kind <= self_kind_nxt;
        end
    end

    // Purpose: choose the command driven in the current state.
    always_comb begin
        unique case (state)
            ST_PRE:  op = OP_PRE;
            ST_REF:  op = OP_REF;
            default: op = OP_NOP;
        endcase
    end

    assign cs_n    = bus.cs_n;
    assign ras_n   = bus.ras_n;
    assign cas_n   = bus.cas_n;
    assign we_n    = bus.we_n;
    assign a10     = (op == OP_PRE);
    assign cke     = !((state == ST_REF && self_kind) ||
                       state == ST_SR_HOLD || state == ST_SR_STAY);
    assign arb_req = (state == ST_REQ);
    assign busy    = (state != ST_IDLE);

    // ---------------- embedded checks ----------------
    localparam int PW = $clog2(T_RP + 2) + 1;
    localparam int LW = $clog2(T_RAS + 2) + 1;
    logic [PW-1:0] since_pre;
    logic [LW-1:0] low_len;
    logic          is_nop;

    assign is_nop = !cs_n && ras_n && cas_n && we_n;

    // Purpose: saturating cycle counts since the last precharge and of cke low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_pre <= '0;
            low_len   <= '0;
        end else begin
            if (!cs_n && !ras_n && cas_n && !we_n) since_pre <= PW'(1);
            else if (since_pre != PW'(T_RP + 1))  since_pre <= since_pre + 1'b1;
            if (cke)                                low_len <= '0;
            else if (low_len != LW'(T_RAS + 1))     low_len <= low_len + 1'b1;
        end
    end

    // R2: a pending bus request is held until granted.
    a_r2_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (arb_req && !arb_gnt) |=> arb_req);

    // R3: a refresh reached from the tRP wait is exactly T_RP after precharge.
    a_r3_rp_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_REF && $past(state) == ST_WAIT_RP) |-> (since_pre == PW'(T_RP)));

    // R8: cke rises only after it has been low for at least T_RAS cycles.
    a_r8_cke_low_min: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cke) |-> (low_len >= LW'(T_RAS)));

    // R8: while cke stays low, only NOP is driven.
    a_r8_low_nop: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke && $past(!cke)) |-> is_nop);

    // R9: the first two cycles after cke rises carry NOP.
    a_r9_exit_nop: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cke) |-> is_nop ##1 is_nop);

    // R12: the arbiter sees busy whenever the bus is requested.
    a_r12_busy_req: assert property (@(posedge clk) disable iff (!rst_n)
        arb_req |-> busy);

endmodule

// File: tb/sdram_refresh_seq_test.sv
module sdram_refresh_seq_test;
    localparam int N     = 40;
    localparam int T_RP  = 3;
    localparam int T_RC  = 7;
    localparam int T_RAS = 5;
    localparam int T_XSR = 8;
    localparam int XSR   = (T_XSR > 2) ? T_XSR : 2;
    localparam int PER   = N + 2 + T_RP;
    localparam int WATCHDOG = 20000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lp_req = 1'b0;
    logic arb_gnt = 1'b0;
    logic arb_req, busy, cs_n, ras_n, cas_n, we_n, cke, a10;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit finished = 0;

    // Monitor-recorded events
    int last_pre = -1000, last_ref = -1000, last_any_ref = -1000;
    int sr_start = 0, exit_cyc = 0, low_len = 0;
    int ref_cnt = 0, sr_cnt = 0, exit_cnt = 0, pre_cnt = 0;
    bit in_exit = 0, prev_cke = 1, have_ref = 0;

    sdram_refresh_seq #(
        .REF_INTERVAL(N), .T_RP(T_RP), .T_RC(T_RC), .T_RAS(T_RAS), .T_XSR(T_XSR)
    ) uut (
        .clk(clk), .rst_n(rst_n), .lp_req(lp_req), .arb_gnt(arb_gnt),
        .arb_req(arb_req), .busy(busy), .cs_n(cs_n), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .cke(cke), .a10(a10)
    );

    always #4 clk = ~clk;   // 125 MHz

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", req, cyc, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    // Continuous protocol monitor sampled away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            automatic logic [3:0] c = {cs_n, ras_n, cas_n, we_n};
            automatic bit is_nop = (c == 4'b0111);
            automatic bit is_pre = (c == 4'b0010);
            automatic bit is_ref = (c == 4'b0001);
            chk(is_nop || is_pre || is_ref, "R1 legal command", int'(c), 7);
            if (is_pre) begin
                chk(a10 == 1'b1, "R3 precharge-all a10", int'(a10), 1);
                chk(cke == 1'b1, "R3 precharge with cke", int'(cke), 1);
                if (have_ref) chk(cyc - last_any_ref >= T_RC, "R5 tRC before precharge",
                                  cyc - last_any_ref, T_RC);
                last_pre = cyc;
                pre_cnt++;
            end
            if (!is_nop && have_ref && cyc - last_any_ref < T_RC && cyc != last_any_ref)
                chk(0, "R5 NOP inside tRC", int'(c), 7);
            if (is_ref && cke) begin
                if (in_exit) begin
                    chk(cyc - exit_cyc == XSR, "R9 exit to refresh", cyc - exit_cyc, XSR);
                    in_exit = 0;
                end else begin
                    chk(cyc - last_pre == T_RP, "R3 tRP spacing", cyc - last_pre, T_RP);
                end
                last_ref = cyc;
                last_any_ref = cyc;
                have_ref = 1;
                ref_cnt++;
            end
            if (is_ref && !cke) begin
                chk(prev_cke == 1'b1, "R7 cke falls with entry", int'(prev_cke), 1);
                chk(cyc - last_pre == T_RP, "R7 tRP before entry", cyc - last_pre, T_RP);
                sr_start = cyc;
                last_any_ref = cyc;
                have_ref = 1;
                sr_cnt++;
            end
            if (!cke && !is_ref) chk(is_nop, "R8 NOP while cke low", int'(c), 7);
            if (!prev_cke && cke) begin
                low_len = cyc - sr_start;
                chk(low_len >= T_RAS + 1, "R8 minimum cke low", low_len, T_RAS + 1);
                in_exit = 1;
                exit_cyc = cyc;
                exit_cnt++;
            end
            if (in_exit && cke && !is_ref) chk(is_nop, "R9 NOP during exit", int'(c), 7);
            prev_cke = cke;
        end
    end

    // Watchdog: a hung run is a failed check and still reports.
    always @(posedge clk) begin
        if (cyc == WATCHDOG && !finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual=%0d expected<%0d cycles", cyc, WATCHDOG);
            summary();
            $finish;
        end
    end

    initial begin
        int k, r, t, p0, s0;
        bit saw_low, saw_high, busy_ok;

        // Reset state (R1)
        repeat (5) @(posedge clk);
        @(negedge clk);
        chk(cke == 1'b1, "R1 reset cke", int'(cke), 1);
        chk({cs_n, ras_n, cas_n, we_n} == 4'b0111, "R1 reset NOP", int'({cs_n, ras_n, cas_n, we_n}), 7);
        chk(arb_req == 1'b0, "R1 reset arb_req", int'(arb_req), 0);
        chk(busy == 1'b0, "R1 reset busy", int'(busy), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 1'b0 && arb_req == 1'b0, "R1 idle after reset", int'(busy), 0);

        // R2: request held while grant withheld
        while (!arb_req) @(negedge clk);
        p0 = pre_cnt;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            chk(arb_req == 1'b1, "R2 request held", int'(arb_req), 1);
            chk(busy == 1'b1, "R12 busy while requesting", int'(busy), 1);
        end
        chk(pre_cnt == p0, "R2 no command before grant", pre_cnt, p0);
        arb_gnt = 1'b1;

        // R4: distributed refresh spacing
        wait (ref_cnt == 1);
        k = ref_cnt; r = last_ref;
        wait (ref_cnt == k + 1);
        chk(last_ref - r == PER, "R4 interval 1", last_ref - r, PER);
        k = ref_cnt; r = last_ref;
        wait (ref_cnt == k + 1);
        chk(last_ref - r == PER, "R4 interval 2", last_ref - r, PER);

        // R6: due and lp_req meet in the same idle cycle
        k = ref_cnt; r = last_ref; s0 = sr_cnt;
        while (cyc != r + N) @(negedge clk);
        lp_req = 1'b1;
        wait (ref_cnt == k + 1);
        chk(last_ref == r + PER, "R6 refresh first", last_ref, r + PER);
        chk(sr_cnt == s0, "R6 no entry before refresh", sr_cnt, s0);
        wait (sr_cnt == s0 + 1);
        chk(sr_start == last_ref + T_RC + 2 + T_RP, "R7 entry timing", sr_start,
            last_ref + T_RC + 2 + T_RP);

        // R8: long self refresh, cke held low and no refreshes
        k = ref_cnt; saw_high = 0; busy_ok = 1;
        for (int i = 0; i < 3 * N; i++) begin
            @(negedge clk);
            if (cke) saw_high = 1;
            if (!busy) busy_ok = 0;
        end
        chk(!saw_high, "R8 cke low while requested", int'(saw_high), 0);
        chk(ref_cnt == k, "R8 no refresh in self refresh", ref_cnt, k);
        chk(busy_ok, "R12 busy through self refresh", int'(busy_ok), 1);
        lp_req = 1'b0;
        t = cyc;
        wait (ref_cnt == k + 1);
        chk(exit_cyc == t + 1, "R9 cke rises after release", exit_cyc, t + 1);
        chk(last_ref == exit_cyc + XSR, "R9 refresh after exit", last_ref, exit_cyc + XSR);
        r = last_ref;
        wait (ref_cnt == k + 2);
        chk(last_ref - r == PER, "R10 resumed interval", last_ref - r, PER);

        // R8: shortest self refresh
        k = ref_cnt; r = last_ref; s0 = sr_cnt; t = exit_cnt;
        lp_req = 1'b1;
        wait (sr_cnt == s0 + 1);
        chk(sr_start == r + T_RC + 2 + T_RP, "R7 entry from idle", sr_start, r + T_RC + 2 + T_RP);
        lp_req = 1'b0;
        wait (exit_cnt == t + 1);
        chk(low_len == T_RAS + 1, "R8 minimum hold exact", low_len, T_RAS + 1);

        // R11: request pulse while busy is ignored
        k = ref_cnt;
        wait (ref_cnt == k + 1);
        lp_req = 1'b1;
        chk(busy == 1'b1, "R12 busy at refresh", int'(busy), 1);
        @(negedge clk);
        lp_req = 1'b0;
        s0 = sr_cnt; saw_low = 0;
        for (int i = 0; i < 3 * N; i++) begin
            @(negedge clk);
            if (!cke) saw_low = 1;
        end
        chk(!saw_low, "R11 cke stays high", int'(saw_low), 0);
        chk(sr_cnt == s0, "R11 no self refresh entry", sr_cnt, s0);
        chk(ref_cnt - (k + 1) >= 2, "R11 refreshes continue", ref_cnt - (k + 1), 2);

        finished = 1;
        summary();
        $finish;
    end
endmodule